// File: doc/BRIEF.md
# Circuit Path Reservation Controller

This block sits at the source end of a hybrid network. Small 32-bit control packets reserve an end-to-end circuit there, and a bulk message then travels over that circuit. The core hands over one message request: a destination, a priority, a flow tag, a beat count and an acknowledge-mode flag. The controller sends a path-setup packet at once. It does not wait for the payload to be ready. It then watches the control receive port for a grant or a blocked reply that names its own path.

After a grant, payload beats pass from the core's stream to the circuit stream. Once the last beat has gone, a teardown packet releases the path. A blocked reply causes a retry after an exponential backoff. In acknowledged mode, the controller also waits for an end-to-end acknowledgment and sends the whole message again if none arrives in time. Only one message can be in flight at a time, and the core is told success or failure through a one-cycle response pulse.

Top module: `circ_path_ctrl`

## Requirements
- R1: After reset, req_ready is 1 and ctl_tx_valid, pl_out_valid and rsp_valid are 0.
- R2: When a request is accepted, the next cycle presents a setup packet on ctl_tx_data even while pl_in_valid is 0. The packet has kind 0 in bits [31:29], the destination in [28:21], the priority in [20:18], the flow in [17:10] and zeros in [9:0]. It stays valid and unchanged until ctl_tx_ready is 1.
- R3: req_ready stays 0 from the acceptance of a request until the cycle in which its response pulse is shown.
- R4: No payload beat reaches pl_out before a matching grant (kind 2) is received. After the grant, a beat passes in each cycle in which pl_in_valid and pl_out_ready are both 1, with the data unchanged.
- R5: Exactly req_len+1 beats are streamed, and pl_out_last marks the final one. A teardown packet (kind 1) with the same bits [28:0] as the setup packet follows.
- R6: In unacknowledged mode, acceptance of the teardown produces a one-cycle rsp_valid with rsp_ok=1, and req_ready returns to 1.
- R7: After a matching blocked reply (kind 3) that is retry number r (counting from 0), the same setup packet is presented again (cfg_backoff_base << r) + 1 cycles after the cycle that consumed the reply.
- R8: A blocked reply that arrives when r equals cfg_max_retry ends the message with rsp_ok=0, and no teardown is sent.
- R9: A received packet counts only if its bits [28:0] equal those of the current setup packet and its kind is the one expected in the current phase. Any other packet changes nothing.
- R10: In acknowledged mode, after the teardown is accepted the controller waits for a matching acknowledgment (kind 4) and then gives rsp_ok=1.
- R11: In acknowledged mode, if no acknowledgment arrives within cfg_ack_timeout+1 cycles, a fresh setup is sent and the payload is streamed again. When cfg_max_retry resends have gone unacknowledged, the next timeout ends the message with rsp_ok=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_backoff_base | input | BO_W | Base backoff delay in cycles |
| cfg_max_retry | input | RTRY_W | Retry limit for blocked setups and for unacknowledged resends |
| cfg_ack_timeout | input | TO_W | Acknowledgment wait limit |
| req_valid | input | 1 | Message request present |
| req_ready | output | 1 | Controller can accept a request |
| req_dest | input | 8 | Destination address |
| req_prio | input | 3 | Priority |
| req_flow | input | 8 | Flow tag |
| req_len | input | LEN_W | Payload beats minus one |
| req_ack_mode | input | 1 | Require an end-to-end acknowledgment |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_ok | output | 1 | 1 for delivered, 0 for failed |
| ctl_tx_valid | output | 1 | Outgoing control packet valid |
| ctl_tx_ready | input | 1 | Control network takes the packet |
| ctl_tx_data | output | 32 | Outgoing control packet |
| ctl_rx_valid | input | 1 | Incoming control packet valid |
| ctl_rx_data | input | 32 | Incoming control packet |
| pl_in_valid | input | 1 | Core payload beat available |
| pl_in_ready | output | 1 | Core payload beat taken |
| pl_in_data | input | DATA_W | Core payload data |
| pl_out_valid | output | 1 | Circuit payload beat valid |
| pl_out_ready | input | 1 | Circuit accepts beat |
| pl_out_data | output | DATA_W | Circuit payload data |
| pl_out_last | output | 1 | Final beat of the message |

## Verification
The hardest case to reach is the second pass through a message in acknowledged mode. Getting there needs a granted path, a full stream, an accepted teardown and then silence long enough to expire the acknowledgment timer. Only after that do the resend setup and the second stream appear. The bench keeps the timeout short and the retry limit at one, and replies to nothing after each teardown. This takes the controller through a resend and then to a final failure. Backoff timing is measured by counting cycles from the consumed blocked reply to the reappearance of the setup packet on two successive retries.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
    localparam int PKT_W    = 32;
    localparam int KIND_W   = 3;
    localparam int DEST_W   = 8;
    localparam int PRIO_W   = 3;
    localparam int FLOW_W   = 8;
    localparam int KIND_LSB = PKT_W - KIND_W;
    localparam int TAG_W    = KIND_LSB;
    localparam int RSVD_W   = TAG_W - DEST_W - PRIO_W - FLOW_W;

    typedef enum logic [KIND_W-1:0] {
        PK_SETUP = 3'd0,
        PK_TEAR  = 3'd1,
        PK_GRANT = 3'd2,
        PK_BLOCK = 3'd3,
        PK_ACK   = 3'd4
    } pkt_kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_WAIT,
        S_BACKOFF,
        S_STREAM,
        S_TEAR,
        S_ACKW
    } cpc_state_e;
endpackage

// File: rtl/cpc_pkt_enc.sv
module cpc_pkt_enc
    import cpc_pkg::*;
(
    input  pkt_kind_e             kind,
    input  logic [DEST_W-1:0]     dest,
    input  logic [PRIO_W-1:0]     prio,
    input  logic [FLOW_W-1:0]     flow,
    output logic [TAG_W-1:0]      tag,
    output logic [PKT_W-1:0]      pkt
);
    always_comb begin
        tag = {dest, prio, flow, {RSVD_W{1'b0}}};
        pkt = {kind, tag};
    end
endmodule

// File: rtl/cpc_pkt_dec.sv
module cpc_pkt_dec
    import cpc_pkg::*;
(
    input  logic                  rx_valid,
    input  logic [PKT_W-1:0]      rx_data,
    input  logic [TAG_W-1:0]      own_tag,
    output logic                  hit_grant,
    output logic                  hit_block,
    output logic                  hit_ack
);
    logic tag_match;

    always_comb begin
        tag_match = rx_valid && (rx_data[TAG_W-1:0] == own_tag);
        hit_grant = tag_match && (rx_data[PKT_W-1:KIND_LSB] == PK_GRANT);
        hit_block = tag_match && (rx_data[PKT_W-1:KIND_LSB] == PK_BLOCK);
        hit_ack   = tag_match && (rx_data[PKT_W-1:KIND_LSB] == PK_ACK);
    end
endmodule

// File: rtl/cpc_backoff.sv
module cpc_backoff #(
    parameter int BO_W   = 8,
    parameter int RTRY_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BO_W-1:0]   base,
    input  logic [RTRY_W-1:0] shift,
    output logic              expired
);
    localparam int CNT_W = BO_W + (1 << RTRY_W) - 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = CNT_W'(base) << shift;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
        expired = (cnt_q == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/circ_path_ctrl.sv
module circ_path_ctrl
    import cpc_pkg::*;
#(
    parameter int LEN_W  = 9,
    parameter int DATA_W = 32,
    parameter int BO_W   = 8,
    parameter int RTRY_W = 3,
    parameter int TO_W   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BO_W-1:0]      cfg_backoff_base,
    input  logic [RTRY_W-1:0]    cfg_max_retry,
    input  logic [TO_W-1:0]      cfg_ack_timeout,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [DEST_W-1:0]    req_dest,
    input  logic [PRIO_W-1:0]    req_prio,
    input  logic [FLOW_W-1:0]    req_flow,
    input  logic [LEN_W-1:0]     req_len,
    input  logic                 req_ack_mode,
    output logic                 rsp_valid,
    output logic                 rsp_ok,
    output logic                 ctl_tx_valid,
    input  logic                 ctl_tx_ready,
    output logic [PKT_W-1:0]     ctl_tx_data,
    input  logic                 ctl_rx_valid,
    input  logic [PKT_W-1:0]     ctl_rx_data,
    input  logic                 pl_in_valid,
    output logic                 pl_in_ready,
    input  logic [DATA_W-1:0]    pl_in_data,
    output logic                 pl_out_valid,
    input  logic                 pl_out_ready,
    output logic [DATA_W-1:0]    pl_out_data,
    output logic                 pl_out_last
);
    typedef struct packed {
        cpc_state_e          st;
        logic [DEST_W-1:0]   dest;
        logic [PRIO_W-1:0]   prio;
        logic [FLOW_W-1:0]   flow;
        logic [LEN_W-1:0]    len;
        logic                ack_mode;
        logic [LEN_W-1:0]    beat;
        logic [RTRY_W-1:0]   retry;
        logic [RTRY_W-1:0]   resend;
        logic [TO_W-1:0]     timer;
        logic                rsp_v;
        logic                rsp_ok;
    } ctl_t;

    ctl_t      q, d;
    pkt_kind_e tx_kind;
    logic [TAG_W-1:0] own_tag;
    logic      hit_grant, hit_block, hit_ack;
    logic      bo_load, bo_expired;

    assign tx_kind = (q.st == S_TEAR) ? PK_TEAR : PK_SETUP;

    cpc_pkt_enc u_enc (
        .kind (tx_kind),
        .dest (q.dest),
        .prio (q.prio),
        .flow (q.flow),
        .tag  (own_tag),
        .pkt  (ctl_tx_data)
    );

    cpc_pkt_dec u_dec (
        .rx_valid  (ctl_rx_valid),
        .rx_data   (ctl_rx_data),
        .own_tag   (own_tag),
        .hit_grant (hit_grant),
        .hit_block (hit_block),
        .hit_ack   (hit_ack)
    );

    cpc_backoff #(
        .BO_W   (BO_W),
        .RTRY_W (RTRY_W)
    ) u_backoff (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (bo_load),
        .base    (cfg_backoff_base),
        .shift   (q.retry),
        .expired (bo_expired)
    );

    always_comb begin
        d        = q;
        d.rsp_v  = 1'b0;
        d.rsp_ok = 1'b0;
        bo_load  = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (req_valid) begin
                    d.st       = S_SETUP;
                    d.dest     = req_dest;
                    d.prio     = req_prio;
                    d.flow     = req_flow;
                    d.len      = req_len;
                    d.ack_mode = req_ack_mode;
                    d.retry    = '0;
                    d.resend   = '0;
                end
            end
            S_SETUP: begin
                if (ctl_tx_ready) begin
                    d.st = S_WAIT;
                end
            end
            S_WAIT: begin
                if (hit_grant) begin
                    d.st   = S_STREAM;
                    d.beat = '0;
                end else if (hit_block) begin
                    if (q.retry == cfg_max_retry) begin
                        d.st     = S_IDLE;
                        d.rsp_v  = 1'b1;
                        d.rsp_ok = 1'b0;
                    end else begin
                        bo_load = 1'b1;
                        d.retry = q.retry + 1'b1;
                        d.st    = S_BACKOFF;
                    end
                end
            end
            S_BACKOFF: begin
                if (bo_expired) begin
                    d.st = S_SETUP;
                end
            end
            S_STREAM: begin
                if (pl_in_valid && pl_out_ready) begin
                    if (q.beat == q.len) begin
                        d.st = S_TEAR;
                    end else begin
                        d.beat = q.beat + 1'b1;
                    end
                end
            end
            S_TEAR: begin
                if (ctl_tx_ready) begin
                    if (q.ack_mode) begin
                        d.st    = S_ACKW;
                        d.timer = '0;
                    end else begin
                        d.st     = S_IDLE;
                        d.rsp_v  = 1'b1;
                        d.rsp_ok = 1'b1;
                    end
                end
            end
            S_ACKW: begin
                if (hit_ack) begin
                    d.st     = S_IDLE;
                    d.rsp_v  = 1'b1;
                    d.rsp_ok = 1'b1;
                end else if (q.timer == cfg_ack_timeout) begin
                    if (q.resend == cfg_max_retry) begin
                        d.st     = S_IDLE;
                        d.rsp_v  = 1'b1;
                        d.rsp_ok = 1'b0;
                    end else begin
                        d.resend = q.resend + 1'b1;
                        d.retry  = '0;
                        d.st     = S_SETUP;
                    end
                end else begin
                    d.timer = q.timer + 1'b1;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        req_ready    = (q.st == S_IDLE);
        ctl_tx_valid = (q.st == S_SETUP) || (q.st == S_TEAR);
        pl_out_valid = (q.st == S_STREAM) && pl_in_valid;
        pl_in_ready  = (q.st == S_STREAM) && pl_out_ready;
        pl_out_data  = pl_in_data;
        pl_out_last  = (q.st == S_STREAM) && (q.beat == q.len);
        rsp_valid    = q.rsp_v;
        rsp_ok       = q.rsp_ok;
    end
endmodule

// File: rtl/cpc_checker.sv
module cpc_checker
    import cpc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             ctl_tx_valid,
    input logic             ctl_tx_ready,
    input logic [PKT_W-1:0] ctl_tx_data,
    input logic             pl_out_valid,
    input logic             pl_out_ready,
    input logic             pl_out_last
);
    AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_tx_valid && !ctl_tx_ready |=> ctl_tx_valid && $stable(ctl_tx_data)); // R2

    AST_SINGLE_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready); // R3

    AST_STREAM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        pl_out_valid |-> !ctl_tx_valid && !req_ready); // R4

    AST_TX_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_tx_valid |-> (ctl_tx_data[PKT_W-1:KIND_LSB] == PK_SETUP) ||
                         (ctl_tx_data[PKT_W-1:KIND_LSB] == PK_TEAR)); // R5

    AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        pl_out_valid && pl_out_ready && pl_out_last |=> !pl_out_valid && ctl_tx_valid); // R5

    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R6

    AST_RSP_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready); // R6
endmodule

bind circ_path_ctrl cpc_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .ctl_tx_valid (ctl_tx_valid),
    .ctl_tx_ready (ctl_tx_ready),
    .ctl_tx_data  (ctl_tx_data),
    .pl_out_valid (pl_out_valid),
    .pl_out_ready (pl_out_ready),
    .pl_out_last  (pl_out_last)
);

// File: tb/circ_path_ctrl_test.sv
`timescale 1ns/1ps
module circ_path_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_backoff_base = 8'd3;
    logic [2:0]  cfg_max_retry = 3'd2;
    logic [15:0] cfg_ack_timeout = 16'd20;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_dest = '0;
    logic [2:0]  req_prio = '0;
    logic [7:0]  req_flow = '0;
    logic [8:0]  req_len = '0;
    logic        req_ack_mode = 1'b0;
    logic        rsp_valid, rsp_ok;
    logic        ctl_tx_valid;
    logic        ctl_tx_ready = 1'b1;
    logic [31:0] ctl_tx_data;
    logic        ctl_rx_valid = 1'b0;
    logic [31:0] ctl_rx_data = '0;
    logic        pl_in_valid = 1'b0;
    logic        pl_in_ready;
    logic [31:0] pl_in_data = 32'hD000_0000;
    logic        pl_out_valid;
    logic        pl_out_ready = 1'b1;
    logic [31:0] pl_out_data;
    logic        pl_out_last;

    circ_path_ctrl uut (.*);

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int tx_cnt = 0;
    int bt_cnt = 0;
    int rsp_cnt = 0;
    logic        rsp_ok_last = 1'b0;
    logic [31:0] tx_log [32];
    logic [31:0] bt_data [32];
    logic        bt_last [32];
    logic [7:0]  cur_d;
    logic [2:0]  cur_p;
    logic [7:0]  cur_f;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ctl_tx_valid && ctl_tx_ready) begin
                tx_log[tx_cnt % 32] = ctl_tx_data;
                tx_cnt = tx_cnt + 1;
            end
            if (pl_out_valid && pl_out_ready) begin
                bt_data[bt_cnt % 32] = pl_out_data;
                bt_last[bt_cnt % 32] = pl_out_last;
                bt_cnt = bt_cnt + 1;
            end
            if (rsp_valid) begin
                rsp_cnt = rsp_cnt + 1;
                rsp_ok_last = rsp_ok;
            end
        end
    end

    always @(posedge clk) begin
        #1;
        pl_in_data = 32'hD000_0000 + bt_cnt;
    end

    function automatic logic [31:0] mk(input logic [2:0] k, input logic [7:0] dd,
                                       input logic [2:0] pp, input logic [7:0] ff);
        return {k, dd, pp, ff, 10'd0};
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [7:0] dd, input logic [2:0] pp, input logic [7:0] ff,
                         input logic [8:0] len, input logic ack);
        cur_d = dd; cur_p = pp; cur_f = ff;
        req_dest = dd; req_prio = pp; req_flow = ff; req_len = len; req_ack_mode = ack;
        req_valid = 1'b1;
        tick();
        req_valid = 1'b0;
    endtask

    task automatic send_raw(input logic [31:0] pkt);
        ctl_rx_valid = 1'b1;
        ctl_rx_data = pkt;
        tick();
        ctl_rx_valid = 1'b0;
    endtask

    task automatic send_own(input logic [2:0] k);
        send_raw(mk(k, cur_d, cur_p, cur_f));
    endtask

    task automatic wait_tx(input int target);
        for (int g = 0; g < 200 && tx_cnt < target; g++) tick();
    endtask

    task automatic wait_bt(input int target);
        for (int g = 0; g < 200 && bt_cnt < target; g++) tick();
    endtask

    task automatic wait_rsp(input int target);
        for (int g = 0; g < 300 && rsp_cnt < target; g++) tick();
    endtask

    task automatic t_reset();
        chk("R1 req_ready", 32'(req_ready), 32'd1);
        chk("R1 ctl_tx_valid", 32'(ctl_tx_valid), 32'd0);
        chk("R1 pl_out_valid", 32'(pl_out_valid), 32'd0);
        chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    endtask

    task automatic t_basic();
        int t0, b0, r0;
        logic [31:0] setup;
        t0 = tx_cnt; b0 = bt_cnt; r0 = rsp_cnt;
        ctl_tx_ready = 1'b0;
        pl_in_valid = 1'b0;
        issue(8'h5A, 3'd5, 8'h3C, 9'd2, 1'b0);
        setup = mk(3'd0, 8'h5A, 3'd5, 8'h3C);
        chk("R3 busy after accept", 32'(req_ready), 32'd0);
        chk("R2 setup without payload", 32'(ctl_tx_valid), 32'd1);
        chk("R2 setup format", ctl_tx_data, setup);
        for (int i = 0; i < 3; i++) tick();
        chk("R2 held under backpressure", ctl_tx_data, setup);
        chk("R2 valid held", 32'(ctl_tx_valid), 32'd1);
        ctl_tx_ready = 1'b1;
        tick();
        chk("R2 one setup logged", 32'(tx_cnt - t0), 32'd1);
        chk("R2 logged setup", tx_log[t0 % 32], setup);
        pl_in_valid = 1'b1;
        send_raw(mk(3'd2, 8'h5A, 3'd5, 8'h3D));
        send_own(3'd4);
        for (int i = 0; i < 3; i++) tick();
        chk("R9 foreign grant ignored", 32'(bt_cnt - b0), 32'd0);
        chk("R4 gated before grant", 32'(pl_out_valid), 32'd0);
        send_own(3'd2);
        wait_bt(b0 + 3);
        chk("R5 beat count", 32'(bt_cnt - b0), 32'd3);
        for (int i = 0; i < 3; i++) begin
            chk("R4 beat data", bt_data[(b0 + i) % 32], 32'hD000_0000 + 32'(b0 + i));
            chk("R5 last flag", 32'(bt_last[(b0 + i) % 32]), (i == 2) ? 32'd1 : 32'd0);
        end
        wait_tx(t0 + 2);
        chk("R5 teardown packet", tx_log[(t0 + 1) % 32], mk(3'd1, 8'h5A, 3'd5, 8'h3C));
        wait_rsp(r0 + 1);
        chk("R6 response ok", 32'(rsp_ok_last), 32'd1);
        chk("R6 ready again", 32'(req_ready), 32'd1);
    endtask

    task automatic t_block();
        int t0, r0, n;
        t0 = tx_cnt; r0 = rsp_cnt;
        cfg_backoff_base = 8'd3;
        cfg_max_retry = 3'd2;
        issue(8'h21, 3'd1, 8'h11, 9'd0, 1'b0);
        wait_tx(t0 + 1);
        send_own(3'd3);
        n = 0;
        while (!ctl_tx_valid && n < 100) begin tick(); n++; end
        chk("R7 first backoff cycles", 32'(n), 32'd4);
        tick();
        chk("R7 retried setup identical", tx_log[(t0 + 1) % 32], mk(3'd0, 8'h21, 3'd1, 8'h11));
        send_own(3'd3);
        n = 0;
        while (!ctl_tx_valid && n < 100) begin tick(); n++; end
        chk("R7 doubled backoff cycles", 32'(n), 32'd7);
        tick();
        send_own(3'd3);
        wait_rsp(r0 + 1);
        chk("R8 failure reported", 32'(rsp_ok_last), 32'd0);
        for (int i = 0; i < 5; i++) tick();
        chk("R8 no teardown", 32'(tx_cnt - t0), 32'd3);
        chk("R8 ready again", 32'(req_ready), 32'd1);
    endtask

    task automatic t_ack();
        int t0, b0, r0;
        t0 = tx_cnt; b0 = bt_cnt; r0 = rsp_cnt;
        cfg_ack_timeout = 16'd20;
        issue(8'h40, 3'd2, 8'h77, 9'd0, 1'b1);
        wait_tx(t0 + 1);
        send_own(3'd2);
        wait_bt(b0 + 1);
        wait_tx(t0 + 2);
        send_raw(mk(3'd4, 8'h40, 3'd2, 8'h78));
        for (int i = 0; i < 3; i++) tick();
        chk("R9 foreign ack ignored", 32'(rsp_cnt - r0), 32'd0);
        chk("R10 still busy", 32'(req_ready), 32'd0);
        send_own(3'd4);
        wait_rsp(r0 + 1);
        chk("R10 acked ok", 32'(rsp_ok_last), 32'd1);
    endtask

    task automatic t_timeout();
        int t0, b0, r0;
        t0 = tx_cnt; b0 = bt_cnt; r0 = rsp_cnt;
        cfg_ack_timeout = 16'd5;
        cfg_max_retry = 3'd1;
        issue(8'h09, 3'd7, 8'hA5, 9'd1, 1'b1);
        wait_tx(t0 + 1);
        send_own(3'd2);
        wait_bt(b0 + 2);
        wait_tx(t0 + 2);
        wait_tx(t0 + 3);
        chk("R11 resend setup", tx_log[(t0 + 2) % 32], mk(3'd0, 8'h09, 3'd7, 8'hA5));
        chk("R11 no response yet", 32'(rsp_cnt - r0), 32'd0);
        send_own(3'd2);
        wait_bt(b0 + 4);
        chk("R11 payload restreamed", 32'(bt_cnt - b0), 32'd4);
        wait_tx(t0 + 4);
        chk("R11 second teardown", tx_log[(t0 + 3) % 32], mk(3'd1, 8'h09, 3'd7, 8'hA5));
        wait_rsp(r0 + 1);
        chk("R11 final failure", 32'(rsp_ok_last), 32'd0);
        chk("R11 response count", 32'(rsp_cnt - r0), 32'd1);
    endtask

    initial begin
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_basic();
        t_block();
        t_ack();
        t_timeout();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule